// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write single bits in an external asynchronous static RAM that holds 64K one-bit words and has separate data-in and data-out pins. The user side offers a request/ready handshake. A request carries a 16-bit address, a write flag and a write bit. A read returns one bit together with a one-cycle valid strobe.

The controller turns every accepted request into a fixed sequence of phases on the memory pins: active-low chip select, active-low write enable, address and data-in. Each phase length is a parameter counted in clock cycles. It is the nanosecond minimum divided by the clock period, rounded up, with a floor of one cycle. The address and data-in are latched when the request is accepted. They change only while chip select is high, so they never move during a write overlap. On a write, chip select always goes low before write enable, so the memory output is driven and then released in the normal way.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, mem_cs_n and mem_we_n are 1, ready is 1, rd_valid is 0 and mem_addr is 0. The memory pins stay like this until the first request is accepted.
- R2: A request is accepted on a clock edge where req and ready are both 1. Ready then stays 0 for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC+RECOV_CYC cycles for a write, and for exactly ACCESS_CYC+RECOV_CYC cycles for a read.
- R3: mem_addr holds the accepted address and never changes while mem_cs_n is 0.
- R4: On a write, mem_cs_n is 0 with mem_we_n at 1 for exactly SETUP_CYC cycles. mem_we_n is then 0 for exactly PULSE_CYC consecutive cycles.
- R5: On a write, mem_din carries the write bit and does not change while mem_cs_n is 0. mem_cs_n stays 0 for exactly HOLD_CYC cycles after mem_we_n returns to 1.
- R6: On a read, mem_we_n stays 1 while mem_cs_n is 0 for ACCESS_CYC cycles. rd_bit takes mem_dout as sampled on the edge that ends that count, and rd_valid is 1 for exactly one cycle.
- R7: After every access, mem_cs_n is 1 for exactly RECOV_CYC cycles before ready returns to 1.
- R8: mem_we_n is 0 only while mem_cs_n is 0.
- R9: A request presented while ready is 0 is ignored. It starts no memory cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wbit | input | 1 | Bit to write |
| ready | output | 1 | Controller idle; can accept a request |
| rd_bit | output | 1 | Last bit read |
| rd_valid | output | 1 | One-cycle strobe with a fresh rd_bit |
| mem_addr | output | 16 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | output | 1 | Memory data-in |
| mem_dout | input | 1 | Memory data-out |

## Verification
The bench's memory model returns the inverted bit until the address has been selected for the full access count. A controller that captures one cycle early therefore reads back wrong data. The model commits data only during the select-and-write overlap. A controller that lets the address or data move inside that window, or that shortens the pulse or hold, would corrupt other words or show wrong run lengths on the pins. Requests held high during a busy cycle are aimed at a different address. A controller that accepts them outside the idle state would write that address or start an extra select cycle. The bench also covers the address extremes and overwriting a word.

// File: rtl/sram_seq_pkg.sv
// Shared types for the asynchronous SRAM access controller.
// Assumes: phases are decoded directly to the memory control pins.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4,
        PH_RECOV   = 3'd5
    } phase_t;

    // Largest of the five phase lengths; sizes the shared phase counter.
    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Down counter that measures the length of one phase.
// Assumes: load_val is the phase length minus one; done is high in the last cycle.
module sram_seq_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Load on a phase entry, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The phase ends in the cycle where the count has reached zero.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: chooses the write or read phase sequence and
// loads the timer with each phase length.
// Assumes: all phase lengths are >= 1 cycle; a request is seen only in PH_IDLE.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 3,
    parameter int unsigned RECOV_CYC  = 1,
    parameter int unsigned CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             tmr_done,
    output phase_t           phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);

    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD  = CNT_W'(RECOV_CYC - 1);

    phase_t nxt;

    // Next phase, timer load and strobes for the current phase.
    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nxt     = PH_WSETUP;
                        tmr_val = SETUP_LD;
                    end else begin
                        nxt     = PH_RACCESS;
                        tmr_val = ACCESS_LD;
                    end
                end
            end
            PH_WSETUP: if (tmr_done) begin
                nxt = PH_WPULSE; tmr_load = 1'b1; tmr_val = PULSE_LD;
            end
            PH_WPULSE: if (tmr_done) begin
                nxt = PH_WHOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
            end
            PH_WHOLD: if (tmr_done) begin
                nxt = PH_RECOV; tmr_load = 1'b1; tmr_val = RECOV_LD;
            end
            PH_RACCESS: if (tmr_done) begin
                nxt = PH_RECOV; tmr_load = 1'b1; tmr_val = RECOV_LD;
                capture = 1'b1;
            end
            PH_RECOV: if (tmr_done) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            phase <= nxt;
    end

endmodule

// File: rtl/sram_seq_capture.sv
// Read-data capture register with a one-cycle valid strobe.
// Assumes: capture is high only on the edge that ends the access count.
module sram_seq_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic mem_dout,
    output logic rd_bit,
    output logic rd_valid
);

    // Keep the sampled bit until the next read; pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_bit <= mem_dout;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top of the asynchronous SRAM access controller. It latches each accepted
// request and decodes the memory control pins from the sequencer phase.
// Assumes: the memory is fully asynchronous, and every timing minimum has been
// turned into whole clock cycles (>= 1) by the integrator.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 3,
    parameter int unsigned RECOV_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wbit,
    output logic              ready,
    output logic              rd_bit,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);

    localparam int unsigned MAX_CYC = cyc_max(SETUP_CYC, PULSE_CYC, HOLD_CYC,
                                              ACCESS_CYC, RECOV_CYC);
    localparam int unsigned CNT_W   = (MAX_CYC <= 2) ? 1 : $clog2(MAX_CYC);

    phase_t           phase;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .RECOV_CYC  (RECOV_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .phase     (phase),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture)
    );

    sram_seq_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .mem_dout (mem_dout),
        .rd_bit   (rd_bit),
        .rd_valid (rd_valid)
    );

    // Address and write bit are loaded only on acceptance, when select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_din  <= 1'b0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_din  <= req_write ? req_wbit : mem_din;
        end
    end

    // Memory control pins and ready, decoded from the phase register.
    always_comb begin
        ready    = (phase == PH_IDLE);
        mem_cs_n = (phase == PH_IDLE) || (phase == PH_RECOV);
        mem_we_n = (phase != PH_WPULSE);
    end

endmodule

// File: rtl/sram_seq_ctrl_checker.sv
// Protocol checker for the SRAM access controller, attached with bind.
// Assumes: it sees the top-level ports only.
module sram_seq_ctrl_checker #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_din
);

    assert_we_inside_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    assert_din_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_din));

    assert_cs_before_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_cs_n));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_we_n));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ready    (ready),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_din  (mem_din)
);

// File: tb/sram_seq_ctrl_bench.sv
// Directed bench for sram_seq_ctrl with a cycle-level model of the memory.
module sram_seq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S = 1;
    localparam int P = 2;
    localparam int H = 2;
    localparam int A = 3;
    localparam int R = 2;
    localparam int WR_BUSY = S + P + H + R;
    localparam int RD_BUSY = A + R;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wbit = 1'b0;
    logic        ready, rd_bit, rd_valid;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_din;
    logic        mem_dout = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W(16), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .ACCESS_CYC(A), .RECOV_CYC(R)
    ) u_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wbit(req_wbit), .ready(ready),
        .rd_bit(rd_bit), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
        .mem_dout(mem_dout)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Memory model: a write lands during the select+write overlap. A read
    // returns the inverted bit until the word has been selected for A cycles.
    bit store [int unsigned];
    int sel_run = 0;

    function automatic bit peek(input int unsigned a);
        return store.exists(a) ? store[a] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) store[int'(mem_addr)] = mem_din;
        if (!mem_cs_n && mem_we_n) sel_run = sel_run + 1;
        else sel_run = 0;
    end

    always @(negedge clk) begin
        if (!mem_cs_n && mem_we_n)
            mem_dout <= (sel_run >= A - 1) ? peek(int'(mem_addr)) : ~peek(int'(mem_addr));
        else
            mem_dout <= 1'b0;
    end

    // Pin-level monitor for phase lengths and stability.
    logic        p_cs = 1'b1, p_we = 1'b1, p_rdy = 1'b1, p_din = 1'b0;
    logic [15:0] p_addr = '0;
    int cs_run = 0, pulse_run = 0, rec_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && p_cs) begin cs_run = 0; pulse_run = 0; end
            if (!mem_we_n && p_we) begin
                check(cs_run == S, "R4 setup before write pulse", cs_run, S);
                check(!mem_cs_n, "R8 select low under write", mem_cs_n, 0);
            end
            if (mem_we_n && !p_we)
                check(pulse_run == P, "R4 write pulse length", pulse_run, P);
            if (mem_cs_n && !p_cs && pulse_run != 0)
                check(cs_run - S == H, "R5 hold after pulse", cs_run - S, H);
            if (ready && !p_rdy)
                check(rec_run == R, "R7 recovery length", rec_run, R);
            if (!mem_cs_n && !p_cs) begin
                check(mem_addr == p_addr, "R3 address steady", mem_addr, p_addr);
                check(mem_din == p_din, "R5 data-in steady", mem_din, p_din);
            end
            if (!mem_we_n && mem_cs_n)
                check(1'b0, "R8 write without select", 1, 0);
            if (!mem_cs_n) begin
                if (mem_we_n) cs_run++; else pulse_run++;
            end
            if (ready) rec_run = 0;
            else if (mem_cs_n) rec_run++;
            p_cs = mem_cs_n; p_we = mem_we_n; p_rdy = ready;
            p_addr = mem_addr; p_din = mem_din;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog expired", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_write(input logic [15:0] a, input logic b);
        int busy;
        while (!ready) @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = a; req_wbit = b;
        @(negedge clk);
        req = 1'b0;
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
        check(busy == WR_BUSY, "R2 write busy length", busy, WR_BUSY);
    endtask

    task automatic do_read(input logic [15:0] a, input logic exp, input string tag);
        int busy, vcnt, welow;
        logic got;
        got = 1'bx;
        while (!ready) @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        busy = 0; vcnt = 0; welow = 0;
        while (!ready) begin
            busy++;
            if (rd_valid) begin vcnt++; got = rd_bit; end
            if (!mem_we_n) welow++;
            @(negedge clk);
        end
        check(busy == RD_BUSY, "R2 read busy length", busy, RD_BUSY);
        check(vcnt == 1, "R6 single valid strobe", vcnt, 1);
        check(welow == 0, "R6 write enable high on read", welow, 0);
        check(got === exp, tag, got, exp);
    endtask

    task automatic t_reset;
        check(mem_cs_n == 1'b1, "R1 select high after reset", mem_cs_n, 1);
        check(mem_we_n == 1'b1, "R1 write enable high after reset", mem_we_n, 1);
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(rd_valid == 1'b0, "R1 no valid after reset", rd_valid, 0);
        check(mem_addr == 16'h0, "R1 address zero after reset", mem_addr, 0);
    endtask

    task automatic t_patterns;
        do_write(16'h0000, 1'b1);
        do_write(16'hFFFF, 1'b1);
        do_write(16'h1234, 1'b0);
        do_write(16'hA5A5, 1'b1);
        do_read(16'h0000, 1'b1, "R6 read low corner");
        do_read(16'hFFFF, 1'b1, "R6 read high corner");
        do_read(16'h1234, 1'b0, "R6 read zero bit");
        do_read(16'hA5A5, 1'b1, "R6 read mixed address");
        do_read(16'h5555, 1'b0, "R6 read unwritten word");
        do_write(16'hFFFF, 1'b0);
        do_read(16'hFFFF, 1'b0, "R6 read after overwrite");
        do_read(16'h0000, 1'b1, "R6 neighbour untouched");
    endtask

    task automatic t_busy_ignore;
        int busy;
        int cs_low;
        while (!ready) @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 16'h0100; req_wbit = 1'b1;
        @(negedge clk);
        req_addr = 16'h0200;
        busy = 0;
        while (!ready) begin
            busy++;
            if (busy == WR_BUSY) req = 1'b0;
            @(negedge clk);
        end
        req = 1'b0;
        check(busy == WR_BUSY, "R9 busy unaffected by held request", busy, WR_BUSY);
        cs_low = 0;
        for (int i = 0; i < 4; i++) begin
            if (!mem_cs_n) cs_low++;
            @(negedge clk);
        end
        check(cs_low == 0, "R9 no extra memory cycle", cs_low, 0);
        do_read(16'h0200, 1'b0, "R9 ignored request wrote nothing");
        do_read(16'h0100, 1'b1, "R9 accepted request written");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_patterns();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule